// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block lets an external SPI master read and write a bank of 32-bit registers inside the chip. The master owns the serial clock. The block runs on a much faster system clock. It passes the serial clock, data-in and chip-select inputs through synchronizers and detects serial-clock edges in the system clock domain. The block always acts as a slave. It samples incoming bits on rising serial-clock edges and changes outgoing bits on falling edges. Both directions send the most significant bit first.

Each frame begins with a command byte. Only the lowest bit of that byte matters: 1 selects a read and 0 selects a write. A 16-bit register address follows the command byte, and after it comes a 32-bit data phase.

- In a read, the block pulses a read strobe toward the register side as soon as the last address bit arrives. It captures the returned word and shifts that word out on the MISO line, which has its own output-enable.
- In a write, the block collects 32 bits. It issues a one-cycle write strobe only when the whole word has arrived while chip select is still low.

Raising chip select before the end of a frame abandons the transfer and floats the output.

Top module: `spi_reg_port`

## Requirements
- R1: After reset, `reg_rd_o`, `reg_wr_o` and `miso_oe_o` are all 0.
- R2: In a frame whose command bit 0 is 1, `reg_rd_o` pulses for exactly one system cycle after the 24th rising SCLK edge. At that point `reg_addr_o` holds the 16 bits received on rising edges 9 to 24, MSB first.
- R3: Bits 7 to 1 of the command byte have no effect on decoding or on the data transferred.
- R4: In a read frame, the 32-bit word present on `reg_rdata_i` during the read strobe appears on `miso_o`, MSB first. The first bit is driven after the falling SCLK edge that follows the 24th rising edge, and each later bit is driven after the next falling edge.
- R5: `miso_oe_o` is 0 during the command and address phases, during every write frame, and whenever SS is high. It is 1 during the 32-bit data phase of a read frame.
- R6: In a frame whose command bit 0 is 0, `reg_wr_o` pulses for exactly one system cycle once the 56th rising edge has been sampled. At that point `reg_wdata_o` holds data bits 25 to 56, MSB first, and `reg_addr_o` holds the address.
- R7: If SS rises before the 56th rising edge, the block issues no write strobe and `miso_oe_o` falls to 0. The next frame then decodes normally from its first bit.
- R8: SCLK and MOSI activity while SS is high produces no strobe and no output enable, and it leaves no partial bit count behind for the next frame.
- R9: Rising SCLK edges after the 56th one in a frame are ignored. They cause no extra strobe and no output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCLK rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ss_n_i | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for MISO; 0 means float |
| reg_addr_o | output | 16 | Register address |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 32 | Read data, valid while `reg_rd_o` is high |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 32 | Write data, valid with `reg_wr_o` |

## Verification
The hardest state to reach is a read frame interrupted partway through the data phase, with the output already enabled. That case must be followed at once by a clean frame, which shows that no leftover bit count or enable survives the abort. The bench drives SS high after 40 SCLK periods of a read frame and checks that the enable was high just before the abort. It then checks that the enable is low afterwards and that a complete read which follows returns the right word. Stray SCLK toggling with SS high and surplus clocks after a full frame are driven the same way, each followed by a frame whose result is compared.

// File: rtl/spi_reg_port.sv
module spi_reg_port #(
  parameter int CMD_W       = 8,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic              ss_n_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              reg_wr_o,
  output logic [DATA_W-1:0] reg_wdata_o
);

  localparam int HDR_W   = CMD_W + ADDR_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] C_CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] C_ADDR_FST  = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] C_HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] C_HDR       = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] C_FRM_LAST  = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] C_FRM       = CNT_W'(FRAME_W);

  logic [SYNC_STAGES-1:0] sclk_sy, mosi_sy, ss_sy;
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '1;
      mosi_sy <= '0;
      ss_sy   <= '1;
      sclk_q  <= 1'b1;
    end else begin
      sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk_i};
      mosi_sy <= {mosi_sy[SYNC_STAGES-2:0], mosi_i};
      ss_sy   <= {ss_sy[SYNC_STAGES-2:0], ss_n_i};
      sclk_q  <= sclk_sy[SYNC_STAGES-1];
    end
  end

  wire sclk_s    = sclk_sy[SYNC_STAGES-1];
  wire mosi_s    = mosi_sy[SYNC_STAGES-1];
  wire ss_s      = ss_sy[SYNC_STAGES-1];
  wire sel       = ~ss_s;
  wire sclk_rise = sel &  sclk_s & ~sclk_q;
  wire sclk_fall = sel & ~sclk_s &  sclk_q;

  logic [CNT_W-1:0]  cnt;
  logic              is_rd;
  logic              tx_on;
  logic [ADDR_W-1:0] addr_sr;
  logic [DATA_W-1:0] rx_sr, tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      is_rd       <= 1'b0;
      tx_on       <= 1'b0;
      addr_sr     <= '0;
      rx_sr       <= '0;
      tx_sr       <= '0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      reg_rd_o    <= 1'b0;
      reg_wr_o    <= 1'b0;
    end else begin
      reg_rd_o <= 1'b0;
      reg_wr_o <= 1'b0;
      if (!sel) begin
        cnt   <= '0;
        tx_on <= 1'b0;
      end else begin
        if (sclk_rise && cnt != C_FRM) begin
          cnt <= cnt + 1'b1;
          if (cnt == C_CMD_LAST) is_rd <= mosi_s;
          if (cnt >= C_ADDR_FST && cnt <= C_HDR_LAST) addr_sr <= {addr_sr[ADDR_W-2:0], mosi_s};
          if (cnt == C_HDR_LAST) begin
            reg_addr_o <= {addr_sr[ADDR_W-2:0], mosi_s};
            reg_rd_o   <= is_rd;
          end
          if (cnt >= C_HDR) rx_sr <= {rx_sr[DATA_W-2:0], mosi_s};
          if (cnt == C_FRM_LAST && !is_rd) begin
            reg_wdata_o <= {rx_sr[DATA_W-2:0], mosi_s};
            reg_wr_o    <= 1'b1;
          end
        end
        if (sclk_fall && is_rd && cnt >= C_HDR) begin
          if (cnt == C_FRM)  tx_on <= 1'b0;
          else if (!tx_on)   tx_on <= 1'b1;
          else               tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
        end
      end
      if (reg_rd_o) tx_sr <= reg_rdata_i;
    end
  end

  assign miso_o    = tx_sr[DATA_W-1];
  assign miso_oe_o = tx_on & sel;

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_o |=> !reg_rd_o);                                             // R2
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o);                                             // R6
  AST_OE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe_o) |-> (cnt == C_HDR) && is_rd);                       // R5
  AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe_o && $past(miso_oe_o) && !$past(sclk_fall)) |-> $stable(miso_o)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ss_s) |-> (!reg_rd_o && !reg_wr_o));                           // R8
  AST_ABORT_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ss_s) |-> !miso_oe_o);                                         // R7
  AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd_o && reg_wr_o));                                            // R3

endmodule

// File: tb/spi_reg_port_tb.sv
module spi_reg_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, mosi = 1'b0, ss_n = 1'b1;
  logic miso, miso_oe, reg_rd, reg_wr;
  logic [15:0] reg_addr;
  logic [31:0] reg_rdata, reg_wdata;

  int checks = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;

  always #5 clk = ~clk;

  spi_reg_port u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .mosi_i(mosi), .ss_n_i(ss_n),
    .miso_o(miso), .miso_oe_o(miso_oe), .reg_addr_o(reg_addr), .reg_rd_o(reg_rd),
    .reg_rdata_i(reg_rdata), .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata)
  );

  function automatic logic [31:0] model(input logic [15:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  assign reg_rdata = model(reg_addr);

  always @(posedge clk) begin
    if (reg_rd) rd_cnt <= rd_cnt + 1;
    if (reg_wr) begin
      wr_cnt  <= wr_cnt + 1;
      wr_addr <= reg_addr;
      wr_data <= reg_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] cmd, input logic [15:0] addr, input logic [31:0] wd,
                       input int nbits, input int extra,
                       output logic [31:0] cap, output int oe_bad);
    logic [55:0] bits;
    bits = {cmd, addr, wd};
    cap = '0;
    oe_bad = 0;
    ss_n = 1'b0;
    wait_cyc(8);
    for (int i = 0; i < nbits + extra; i++) begin
      sclk = 1'b0;
      mosi = (i < 56) ? bits[55-i] : 1'b1;
      wait_cyc(8);
      if (i >= 24 && i < 56 && cmd[0]) begin
        if (!miso_oe) oe_bad++;
        cap = {cap[30:0], miso};
      end else if (miso_oe) oe_bad++;
      sclk = 1'b1;
      wait_cyc(8);
    end
    ss_n = 1'b1;
    wait_cyc(8);
  endtask

  task automatic t_reset;
    chk(reg_rd == 0 && reg_wr == 0, "R1 strobes", {reg_rd, reg_wr}, 0);
    chk(miso_oe == 0, "R1 oe", miso_oe, 0);
  endtask

  task automatic t_read(input logic [7:0] cmd, input logic [15:0] addr);
    logic [31:0] cap; int bad; int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    frame(cmd, addr, 32'h0, 56, 0, cap, bad);
    chk(rd_cnt == r0 + 1 && wr_cnt == w0, "R2 one read strobe", rd_cnt - r0, 1);
    chk(reg_addr == addr, "R2 address", reg_addr, addr);
    chk(cap == model(addr), "R4 read data", cap, model(addr));
    chk(bad == 0, "R5 oe during read", bad, 0);
    chk(miso_oe == 0, "R5 oe after frame", miso_oe, 0);
  endtask

  task automatic t_write(input logic [7:0] cmd, input logic [15:0] addr, input logic [31:0] d, input int extra);
    logic [31:0] cap; int bad; int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    frame(cmd, addr, d, 56, extra, cap, bad);
    chk(wr_cnt == w0 + 1, "R6 one write strobe", wr_cnt - w0, 1);
    chk(rd_cnt == r0, "R6 no read strobe", rd_cnt - r0, 0);
    chk(wr_addr == addr, "R6 write address", wr_addr, addr);
    chk(wr_data == d, "R6 write data", wr_data, d);
    chk(bad == 0, "R5 oe low in write", bad, 0);
  endtask

  task automatic t_abort;
    logic [31:0] cap; int bad; int w0;
    w0 = wr_cnt;
    frame(8'h00, 16'h0BAD, 32'hCAFEF00D, 50, 0, cap, bad);
    chk(wr_cnt == w0, "R7 aborted write no strobe", wr_cnt - w0, 0);
    frame(8'h01, 16'h3C3C, 32'h0, 40, 0, cap, bad);
    chk(bad == 0, "R7 oe high before abort", bad, 0);
    chk(miso_oe == 0, "R7 oe low after abort", miso_oe, 0);
    t_read(8'h01, 16'h7E81);
  endtask

  task automatic t_idle_sclk;
    int r0, w0; int oe_seen = 0;
    r0 = rd_cnt; w0 = wr_cnt;
    for (int i = 0; i < 30; i++) begin
      sclk = 1'b0; mosi = i[0];
      wait_cyc(8);
      if (miso_oe) oe_seen++;
      sclk = 1'b1;
      wait_cyc(8);
    end
    chk(rd_cnt == r0 && wr_cnt == w0, "R8 no strobe while deselected", rd_cnt + wr_cnt - r0 - w0, 0);
    chk(oe_seen == 0, "R8 no oe while deselected", oe_seen, 0);
    t_write(8'h00, 16'h1357, 32'h2468ACE0, 0);
  endtask

  task automatic t_extra;
    logic [31:0] cap; int bad; int r0;
    t_write(8'h80, 16'hF00F, 32'h89ABCDEF, 10);
    r0 = rd_cnt;
    frame(8'h01, 16'h0042, 32'h0, 56, 10, cap, bad);
    chk(rd_cnt == r0 + 1, "R9 single read strobe with surplus clocks", rd_cnt - r0, 1);
    chk(bad == 0, "R9 oe low during surplus clocks", bad, 0);
    chk(cap == model(16'h0042), "R9 read data", cap, model(16'h0042));
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    wait_cyc(4);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_read(8'h01, 16'h1234);
    t_read(8'hFF, 16'hFFFF);   // R3 upper bits set
    t_read(8'h71, 16'h0000);   // R3
    t_write(8'h00, 16'hABCD, 32'hDEADBEEF, 0);
    t_write(8'hFE, 16'h8001, 32'h00000001, 0); // R3
    t_abort();
    t_idle_sclk();
    t_extra();
    summary();
  end
endmodule